// File: doc/BRIEF.md
# Processor Reset and Boot Sequencer

This block owns the reset state of a small signal-processing core. An active-low reset pin puts the core into reset at once, with no clock edge needed. While the pin stays low, the block drives fixed preset values onto the core control registers. These are the eight address modifiers, the interrupt priority word, the bus wait-state word, the stack pointer, the status word and the operating-mode word.

Release of the pin passes through a two-flop synchroniser. The cycle after the synchronised release, a one-clock strobe captures the two mode-select pins into the chip-mode bits. The start address is then derived from the captured mode. Three enables follow in order: fetch, then decode one cycle later, then execute one cycle after that. As a result, the first instruction executes two cycles after its fetch. Each enable stays high once raised, until the next reset.

Top module: `core_boot_seq`

## Requirements
- R1: While the core is in reset, every 16-bit lane of `addr_mod_o` (eight lanes, lane k in bits 16k+15..16k) reads 0xFFFF.
- R2: While the core is in reset, `int_prio_o` and `stack_ptr_o` read zero.
- R3: While the core is in reset, `bus_wait_o` reads 0xFFFF, which means fifteen wait states on every external access.
- R4: While the core is in reset, `status_o` reads 0x0300. The two interrupt-mask bits (9 and 8) are set. The scaling, trace, loop-flag and condition-code bits are clear.
- R5: While the core is in reset, bits 7..2 of `opmode_o` read zero. Bit 2 is data-ROM enable, bit 6 is stop delay and bit 7 is memory strobe.
- R6: A falling edge on `rst_pin_n` drops `core_rst_n_o`, `mode_strobe_o` and all three enables at once, without waiting for a clock edge.
- R7: After `rst_pin_n` goes high, `core_rst_n_o` rises on the second rising clock edge.
- R8: `mode_strobe_o` is high for exactly one cycle. That cycle starts at the first edge after `core_rst_n_o` rises.
- R9: `opmode_o[1:0]` takes `{mode_b, mode_a}` at the edge that ends the strobe cycle. At all other times, including during reset, those bits ignore the mode pins.
- R10: `boot_pc_o` is 0xE000 when the captured mode is 2, and 0x0000 for modes 0, 1 and 3.
- R11: `fetch_en_o` rises at the edge that ends the strobe cycle. `decode_en_o` rises one edge later and `exec_en_o` one edge after that. Each stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| mode_a | input | 1 | Mode-select pin, low bit of chip mode |
| mode_b | input | 1 | Mode-select pin, high bit of chip mode |
| addr_mod_o | output | 128 | Eight 16-bit address modifier registers |
| int_prio_o | output | 16 | Interrupt priority register |
| bus_wait_o | output | 16 | Bus wait-state control register |
| stack_ptr_o | output | 6 | Stack pointer |
| status_o | output | 16 | Status register |
| opmode_o | output | 8 | Operating-mode register, chip mode in bits 1..0 |
| core_rst_n_o | output | 1 | Synchronised core reset, active low |
| mode_strobe_o | output | 1 | One-cycle mode capture pulse |
| boot_pc_o | output | 16 | Start program address |
| fetch_en_o | output | 1 | Instruction fetch enable |
| decode_en_o | output | 1 | Instruction decode enable |
| exec_en_o | output | 1 | Instruction execute enable |

## Verification
The bench boots in all four modes. It counts the edges from pin release to the synchronised release, the strobe, the fetch, the decode and the execute. A design that skipped a synchroniser stage, or merged fetch with decode, would be one cycle early at a fixed sample point. It toggles the mode pins during reset and again after boot. A latch left open would make the chip-mode bits follow the pins. Mode 3 is the boot-address corner: a decoder that tested only the high mode bit would wrongly start it at 0xE000. Reset is then asserted mid-cycle and checked before any clock edge, which catches a synchronous-only assertion path.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int unsigned PC_W      = 16;
  localparam int unsigned MODE_W    = 2;
  localparam logic [MODE_W-1:0] HIGH_BOOT_MODE = 2'd2;
  localparam logic [PC_W-1:0]   HIGH_BOOT_PC   = 16'hE000;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_LATCH,
    ST_FETCH,
    ST_DECODE,
    ST_RUN
  } seq_state_e;

  // Start address chosen from the captured chip mode.
  function automatic logic [PC_W-1:0] boot_addr(input logic [MODE_W-1:0] mode);
    return (mode == HIGH_BOOT_MODE) ? HIGH_BOOT_PC : '0;
  endfunction

  // Status preset: interrupt mask pair at bits 9..8, everything else clear.
  function automatic logic [15:0] status_preset();
    logic [15:0] v;
    v = '0;
    v[9] = 1'b1;
    v[8] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_pin_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) sh_q <= '0;
    else            sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sh_q[STAGES-1];

  // R7: release reaches the core only after the pin has been high for a cycle
  p_release_synced_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(rst_core_n) |-> $past(rst_pin_n));
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o,
  output logic fetch_en_o,
  output logic decode_en_o,
  output logic exec_en_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_HOLD:   state_d = ST_LATCH;
      ST_LATCH:  state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

  assign strobe_o    = (state_q == ST_LATCH);
  assign fetch_en_o  = (state_q == ST_FETCH) || (state_q == ST_DECODE) || (state_q == ST_RUN);
  assign decode_en_o = (state_q == ST_DECODE) || (state_q == ST_RUN);
  assign exec_en_o   = (state_q == ST_RUN);

  // R8: capture strobe lasts one clock
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  // R11: decode only begins after a fetch cycle
  p_decode_after_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decode_en_o) |-> $past(fetch_en_o));
  // R11: execute begins right after decode, never directly after fetch
  p_exec_after_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_en_o) |-> ($past(decode_en_o) && !$past(exec_en_o)));
  // R11: enables never drop while out of reset
  p_exec_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en_o |=> exec_en_o);
endmodule

// File: rtl/boot_ctl_regs.sv
module boot_ctl_regs
  import boot_pkg::*;
#(
  parameter int unsigned N_MOD = 8,
  parameter int unsigned REG_W = 16,
  parameter int unsigned SP_W  = 6,
  parameter int unsigned OMR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MODE_W-1:0]      mode_pins,
  input  logic                   load_mode,
  output logic [N_MOD*REG_W-1:0] addr_mod_o,
  output logic [REG_W-1:0]       int_prio_o,
  output logic [REG_W-1:0]       bus_wait_o,
  output logic [SP_W-1:0]        stack_ptr_o,
  output logic [REG_W-1:0]       status_o,
  output logic [OMR_W-1:0]       opmode_o,
  output logic [MODE_W-1:0]      mode_o
);
  localparam int unsigned CTL_W = OMR_W - MODE_W;
  localparam logic [REG_W-1:0] SR_PRESET = REG_W'(status_preset());

  // Modifier lanes: one preset register per lane
  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    logic [REG_W-1:0] mod_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mod_q <= '1;
      else        mod_q <= mod_q;
    end
    assign addr_mod_o[g*REG_W +: REG_W] = mod_q;
  end

  logic [REG_W-1:0]  ipr_q, bcr_q, sr_q;
  logic [SP_W-1:0]   sp_q;
  logic [CTL_W-1:0]  omr_ctl_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipr_q     <= '0;
      bcr_q     <= '1;
      sr_q      <= SR_PRESET;
      sp_q      <= '0;
      omr_ctl_q <= '0;
    end else begin
      ipr_q     <= ipr_q;
      bcr_q     <= bcr_q;
      sr_q      <= sr_q;
      sp_q      <= sp_q;
      omr_ctl_q <= omr_ctl_q;
    end
  end

  // Chip mode is not touched by reset; it loads only on the capture strobe
  always_ff @(posedge clk) begin
    if (load_mode) mode_q <= mode_pins;
  end

  assign int_prio_o  = ipr_q;
  assign bus_wait_o  = bcr_q;
  assign status_o    = sr_q;
  assign stack_ptr_o = sp_q;
  assign mode_o      = mode_q;
  assign opmode_o    = {omr_ctl_q, mode_q};

  // R9: chip mode only moves in the cycle after a strobe
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_mode) |-> $stable(mode_q));
endmodule

// File: rtl/core_boot_seq.sv
module core_boot_seq
  import boot_pkg::*;
#(
  parameter int unsigned N_MOD       = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned SP_W        = 6,
  parameter int unsigned OMR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_pin_n,
  input  logic                   mode_a,
  input  logic                   mode_b,
  output logic [N_MOD*REG_W-1:0] addr_mod_o,
  output logic [REG_W-1:0]       int_prio_o,
  output logic [REG_W-1:0]       bus_wait_o,
  output logic [SP_W-1:0]        stack_ptr_o,
  output logic [REG_W-1:0]       status_o,
  output logic [OMR_W-1:0]       opmode_o,
  output logic                   core_rst_n_o,
  output logic                   mode_strobe_o,
  output logic [PC_W-1:0]        boot_pc_o,
  output logic                   fetch_en_o,
  output logic                   decode_en_o,
  output logic                   exec_en_o
);
  logic              rst_core_n;
  logic              strobe;
  logic [MODE_W-1:0] mode_cur;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .rst_core_n (rst_core_n)
  );

  boot_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .strobe_o    (strobe),
    .fetch_en_o  (fetch_en_o),
    .decode_en_o (decode_en_o),
    .exec_en_o   (exec_en_o)
  );

  boot_ctl_regs #(
    .N_MOD (N_MOD),
    .REG_W (REG_W),
    .SP_W  (SP_W),
    .OMR_W (OMR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .mode_pins   ({mode_b, mode_a}),
    .load_mode   (strobe),
    .addr_mod_o  (addr_mod_o),
    .int_prio_o  (int_prio_o),
    .bus_wait_o  (bus_wait_o),
    .stack_ptr_o (stack_ptr_o),
    .status_o    (status_o),
    .opmode_o    (opmode_o),
    .mode_o      (mode_cur)
  );

  assign core_rst_n_o  = rst_core_n;
  assign mode_strobe_o = strobe;
  assign boot_pc_o     = boot_addr(mode_cur);

  // R11: the first fetch follows the capture strobe directly
  p_fetch_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(fetch_en_o) |-> $past(strobe));
  // R10: start address holds once fetching has begun
  p_boot_pc_steady_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fetch_en_o && $past(fetch_en_o)) |-> $stable(boot_pc_o));
endmodule

// File: tb/sim_core_boot_seq.sv
module sim_core_boot_seq;
  logic         clk = 1'b0;
  logic         rst_pin_n = 1'b1;
  logic         mode_a = 1'b0;
  logic         mode_b = 1'b0;
  logic [127:0] addr_mod_o;
  logic [15:0]  int_prio_o, bus_wait_o, status_o, boot_pc_o;
  logic [5:0]   stack_ptr_o;
  logic [7:0]   opmode_o;
  logic         core_rst_n_o, mode_strobe_o, fetch_en_o, decode_en_o, exec_en_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_boot_seq u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .mode_a(mode_a), .mode_b(mode_b),
    .addr_mod_o(addr_mod_o), .int_prio_o(int_prio_o), .bus_wait_o(bus_wait_o),
    .stack_ptr_o(stack_ptr_o), .status_o(status_o), .opmode_o(opmode_o),
    .core_rst_n_o(core_rst_n_o), .mode_strobe_o(mode_strobe_o), .boot_pc_o(boot_pc_o),
    .fetch_en_o(fetch_en_o), .decode_en_o(decode_en_o), .exec_en_o(exec_en_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pc(input logic [1:0] m);
    if (m == 2'b10) return 16'hE000;
    return 16'h0000;
  endfunction

  task automatic t_presets();
    chk("R1 modifiers", addr_mod_o, {128{1'b1}});
    chk("R2 int prio", int_prio_o, 0);
    chk("R2 stack ptr", stack_ptr_o, 0);
    chk("R3 bus wait", bus_wait_o, 16'hFFFF);
    chk("R4 status", status_o, 16'h0300);
    chk("R5 opmode ctl", opmode_o[7:2], 0);
  endtask

  task automatic t_boot(input logic [1:0] m);
    mode_b = m[1];
    mode_a = m[0];
    @(negedge clk);
    rst_pin_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      #1;
      case (k)
        1: chk("R7 still reset", core_rst_n_o, 0);
        2: begin
          chk("R7 release", core_rst_n_o, 1);
          chk("R8 no strobe yet", mode_strobe_o, 0);
        end
        3: begin
          chk("R8 strobe", mode_strobe_o, 1);
          chk("R11 no fetch in strobe", fetch_en_o, 0);
        end
        4: begin
          chk("R8 strobe single", mode_strobe_o, 0);
          chk("R11 fetch", fetch_en_o, 1);
          chk("R11 no decode yet", decode_en_o, 0);
          chk("R9 mode captured", opmode_o[1:0], m);
          chk("R10 boot pc", boot_pc_o, exp_pc(m));
          mode_a = ~m[0];
          mode_b = ~m[1];
        end
        5: begin
          chk("R11 decode", decode_en_o, 1);
          chk("R11 no exec yet", exec_en_o, 0);
        end
        default: begin
          chk("R11 exec", exec_en_o, 1);
          chk("R11 fetch held", fetch_en_o, 1);
          chk("R9 pins ignored after boot", opmode_o[1:0], m);
          chk("R10 boot pc held", boot_pc_o, exp_pc(m));
        end
      endcase
    end
  endtask

  task automatic t_assert_reset(input logic [1:0] held);
    @(negedge clk);
    #0.5;
    rst_pin_n = 1'b0;
    #0.5;
    chk("R6 core reset immediate", core_rst_n_o, 0);
    chk("R6 exec dropped", exec_en_o, 0);
    chk("R6 fetch dropped", fetch_en_o, 0);
    chk("R6 decode dropped", decode_en_o, 0);
    chk("R6 strobe low", mode_strobe_o, 0);
    t_presets();
    mode_a = ~mode_a;
    mode_b = ~mode_b;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 pins ignored in reset", opmode_o[1:0], held);
    chk("R6 stays in reset", core_rst_n_o, 0);
  endtask

  initial begin
    #1 rst_pin_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R6 reset state", core_rst_n_o, 0);
    chk("R11 enables off", {fetch_en_o, decode_en_o, exec_en_o}, 0);
    t_presets();
    for (int m = 0; m < 4; m++) begin
      t_boot(m[1:0]);
      t_assert_reset(m[1:0]);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule